// File: doc/BRIEF.md
# Four-Wire Serial EEPROM Slave

A synthesizable behavioural model of a small non-volatile memory that answers on a four-wire serial bus: select, serial clock, data in and data out. Storage is 128 words of 16 bits, kept in registers. A fast system clock oversamples the bus pins through synchronizers. Rising serial-clock edges are detected inside the block and shift the instruction in. Data out is modelled as a value plus an output-enable, so the surrounding logic can build the tri-state pad.

An instruction is a start bit of 1, a 2-bit opcode and an 8-bit address field whose top bit does not select a word. Three opcodes address a word: read, write and erase. The fourth opcode uses the top two address-field bits as a sub-command: write-enable, write-disable, erase-all and write-all. A write programs the word directly, with no erase needed first. Every modifying instruction starts a self-timed programming cycle when select falls. The next time select is raised, data out shows busy (0) or ready (1). A read keeps streaming the following words for as long as the serial clock runs.

Top module: `mw_eeprom`

## Requirements
- R1: After reset, do_oe_o is 0, every word reads 16'hFFFF, and modifying instructions are locked.
- R2: Within a few system clocks of select going low, do_oe_o is 0 and any instruction in progress is dropped.
- R3: A read (start 1, opcode 10, address field) drives a dummy 0 after the last address bit, then 16 data bits MSB first, each one changing after a rising serial-clock edge.
- R4: A read that keeps clocking streams the next words in order, wrapping from word 127 to word 0.
- R5: Once enabled, a write (opcode 01 plus 16 data bits, MSB first) replaces the addressed word, with no erase needed first.
- R6: Write, erase, erase-all and write-all have no effect after reset or after write-disable (opcode 00, sub-code 00), until write-enable (opcode 00, sub-code 11) is issued.
- R7: An enabled erase (opcode 11) sets the addressed word to 16'hFFFF.
- R8: An enabled erase-all (opcode 00, sub-code 10) sets every word to 16'hFFFF. An enabled write-all (opcode 00, sub-code 01 plus 16 data bits) sets every word to the data.
- R9: When select is raised during programming, do_oe_o is 1 and do_o is 0. do_o goes to 1 once PROG_CYCLES system clocks have passed since programming began.
- R10: An instruction that starts while programming is in progress is ignored entirely, including bits that arrive after programming has finished.
- R11: An instruction that is cut short by select going low does not start programming and changes no word.
- R12: The top bit of the 8-bit address field does not take part in selecting a word.
- R13: Zero bits clocked in before the start bit are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock that oversamples the bus |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cs_i | input | 1 | Chip select, active high |
| sk_i | input | 1 | Serial clock |
| di_i | input | 1 | Serial data in |
| do_o | output | 1 | Serial data out, or ready status |
| do_oe_o | output | 1 | Output enable for do_o; 0 means high impedance |

## Verification
The bench goes after the read stream crossing from word 127 to word 0. A design with a bad address increment would return the wrong word there, or stop streaming. It sends an address with the top bit set to both read and write, so a design that decodes eight address bits would touch another word. It also sends leading zeros before the start bit, which a design that counts bits from select would read as an opcode. Writes are tried while locked, while busy, and after being cut short by select falling. A design with a weak lock, a missing busy gate or early commit would change a stored word in these cases. The bench checks that each one changes nothing.

// File: rtl/mw_eeprom_pkg.sv
package mw_eeprom_pkg;
  typedef enum logic [2:0] {
    OP_NONE, OP_READ, OP_WRITE, OP_ERASE, OP_ERAL, OP_WRAL, OP_EWEN, OP_EWDS
  } op_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_HDR, ST_READ, ST_DATA, ST_DONE
  } st_e;
endpackage

// File: rtl/mw_pin_sync.sv
module mw_pin_sync #(
  parameter int N = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] d_i,
  output logic [N-1:0] q_o
);
  logic [N-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/mw_prog_timer.sv
module mw_prog_timer #(
  parameter int CYCLES = 500000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic launch_i,
  output logic busy_o
);
  localparam int CW = $clog2(CYCLES + 1);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cnt_q <= '0;
    else if (launch_i)     cnt_q <= CW'(CYCLES);
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign busy_o = (cnt_q != '0);

  // R9: programming reports busy right after launch
  a_r9_busy_after_launch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    launch_i |=> busy_o);
endmodule

// File: rtl/mw_word_array.sv
module mw_word_array #(
  parameter int WORDS = 128,
  parameter int WIDTH = 16,
  parameter int AW    = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_one_i,
  input  logic             we_all_i,
  input  logic [AW-1:0]    waddr_i,
  input  logic [WIDTH-1:0] wdata_i,
  input  logic [AW-1:0]    raddr_i,
  output logic [WIDTH-1:0] rdata_o
);
  logic [WIDTH-1:0] mem_q [WORDS];

  for (genvar i = 0; i < WORDS; i++) begin : g_word
    logic hit;
    assign hit = we_all_i | (we_one_i & (waddr_i == AW'(i)));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)  mem_q[i] <= '1;
      else if (hit) mem_q[i] <= wdata_i;
    end
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/mw_cmd_ctrl.sv
module mw_cmd_ctrl
  import mw_eeprom_pkg::*;
#(
  parameter int WIDTH = 16,
  parameter int AW    = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cs_i,
  input  logic             sk_i,
  input  logic             di_i,
  input  logic             busy_i,
  input  logic [WIDTH-1:0] rdata_i,
  output logic [AW-1:0]    raddr_o,
  output logic [AW-1:0]    waddr_o,
  output logic             launch_o,
  output logic             we_one_o,
  output logic             we_all_o,
  output logic [WIDTH-1:0] wdata_o,
  output logic             do_o,
  output logic             do_oe_o
);
  localparam int HW      = AW + 3;  // opcode(2) + address field(AW+1)
  localparam int CNT_MAX = (WIDTH > HW) ? WIDTH : HW;
  localparam int CW      = $clog2(CNT_MAX);

  logic cs_d, sk_d;
  logic sk_rise, cs_rise, cs_fall;
  st_e  state_q;
  op_e  op_q, op_dec;
  logic [CW-1:0]    cnt_q;
  logic [HW-2:0]    hdr_q;
  logic [HW-1:0]    hdr_full;
  logic [1:0]       opc, ctl;
  logic [AW-1:0]    hdr_addr, waddr_q, rd_addr_q;
  logic [WIDTH-1:0] data_q, rd_sh_q;
  logic             wen_q, armed_q, launch_q, status_q, dout_q;

  assign sk_rise  = cs_i & sk_i & ~sk_d;
  assign cs_rise  = cs_i & ~cs_d;
  assign cs_fall  = ~cs_i & cs_d;
  assign hdr_full = {hdr_q, di_i};
  assign opc      = hdr_full[HW-1:HW-2];
  assign ctl      = hdr_full[AW:AW-1];
  assign hdr_addr = hdr_full[AW-1:0];

  always_comb begin
    unique case (opc)
      2'b10:   op_dec = OP_READ;
      2'b01:   op_dec = OP_WRITE;
      2'b11:   op_dec = OP_ERASE;
      default: begin
        unique case (ctl)
          2'b11:   op_dec = OP_EWEN;
          2'b00:   op_dec = OP_EWDS;
          2'b10:   op_dec = OP_ERAL;
          default: op_dec = OP_WRAL;
        endcase
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cs_d      <= 1'b0;
      sk_d      <= 1'b0;
      state_q   <= ST_IDLE;
      op_q      <= OP_NONE;
      cnt_q     <= '0;
      hdr_q     <= '0;
      waddr_q   <= '0;
      rd_addr_q <= '0;
      data_q    <= '0;
      rd_sh_q   <= '0;
      wen_q     <= 1'b0;
      armed_q   <= 1'b0;
      launch_q  <= 1'b0;
      status_q  <= 1'b0;
      dout_q    <= 1'b0;
    end else begin
      cs_d     <= cs_i;
      sk_d     <= sk_i;
      launch_q <= 1'b0;
      if (!cs_i) begin
        // select low: drop everything, commit a complete modifying instruction
        state_q  <= ST_IDLE;
        cnt_q    <= '0;
        status_q <= 1'b0;
        armed_q  <= 1'b0;
        if (cs_fall && armed_q && wen_q && !busy_i) launch_q <= 1'b1;
      end else begin
        if (cs_rise && busy_i) status_q <= 1'b1;
        if (sk_rise) begin
          unique case (state_q)
            ST_IDLE: if (di_i) begin
              if (busy_i) state_q <= ST_DONE;  // swallow the whole instruction
              else begin
                state_q  <= ST_HDR;
                status_q <= 1'b0;
                cnt_q    <= '0;
              end
            end
            ST_HDR: begin
              hdr_q <= hdr_full[HW-2:0];
              cnt_q <= cnt_q + 1'b1;
              if (cnt_q == CW'(HW - 1)) begin
                cnt_q   <= '0;
                op_q    <= op_dec;
                waddr_q <= hdr_addr;
                unique case (op_dec)
                  OP_READ: begin
                    state_q   <= ST_READ;
                    rd_addr_q <= hdr_addr;
                    dout_q    <= 1'b0;
                  end
                  OP_WRITE, OP_WRAL: state_q <= ST_DATA;
                  OP_ERASE, OP_ERAL: begin
                    state_q <= ST_DONE;
                    armed_q <= 1'b1;
                  end
                  OP_EWEN: begin
                    state_q <= ST_DONE;
                    wen_q   <= 1'b1;
                  end
                  default: begin
                    state_q <= ST_DONE;
                    wen_q   <= 1'b0;
                  end
                endcase
              end
            end
            ST_READ: begin
              dout_q  <= (cnt_q == '0) ? rdata_i[WIDTH-1] : rd_sh_q[WIDTH-1];
              rd_sh_q <= (cnt_q == '0) ? (rdata_i << 1) : (rd_sh_q << 1);
              if (cnt_q == CW'(WIDTH - 1)) begin
                cnt_q     <= '0;
                rd_addr_q <= rd_addr_q + 1'b1;
              end else begin
                cnt_q <= cnt_q + 1'b1;
              end
            end
            ST_DATA: begin
              data_q <= {data_q[WIDTH-2:0], di_i};
              cnt_q  <= cnt_q + 1'b1;
              if (cnt_q == CW'(WIDTH - 1)) begin
                state_q <= ST_DONE;
                armed_q <= 1'b1;
              end
            end
            default: ;
          endcase
        end
      end
    end
  end

  assign raddr_o  = rd_addr_q;
  assign waddr_o  = waddr_q;
  assign launch_o = launch_q;
  assign we_one_o = launch_q & ((op_q == OP_WRITE) | (op_q == OP_ERASE));
  assign we_all_o = launch_q & ((op_q == OP_ERAL) | (op_q == OP_WRAL));
  assign wdata_o  = ((op_q == OP_ERASE) | (op_q == OP_ERAL)) ? '1 : data_q;
  assign do_o     = status_q ? ~busy_i : dout_q;
  assign do_oe_o  = status_q | (state_q == ST_READ);

  // R11: select low returns the decoder to idle
  a_r11_cs_low_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cs_i |=> state_q == ST_IDLE);
  // R6: no programming while locked
  a_r6_launch_unlocked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    launch_q |-> wen_q);
  // R3: dummy zero follows the read header
  a_r3_dummy_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sk_rise && state_q == ST_HDR && cnt_q == CW'(HW - 1) && op_dec == OP_READ)
      |=> (state_q == ST_READ && !dout_q));
endmodule

// File: rtl/mw_eeprom.sv
module mw_eeprom #(
  parameter int WORDS       = 128,
  parameter int WIDTH       = 16,
  parameter int PROG_CYCLES = 500000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cs_i,
  input  logic sk_i,
  input  logic di_i,
  output logic do_o,
  output logic do_oe_o
);
  localparam int AW = $clog2(WORDS);

  logic [2:0]       pins_s;
  logic             busy, launch, we_one, we_all;
  logic [AW-1:0]    raddr, waddr;
  logic [WIDTH-1:0] rdata, wdata;

  mw_pin_sync #(.N(3)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({cs_i, sk_i, di_i}),
    .q_o   (pins_s)
  );

  mw_cmd_ctrl #(.WIDTH(WIDTH), .AW(AW)) u_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .cs_i    (pins_s[2]),
    .sk_i    (pins_s[1]),
    .di_i    (pins_s[0]),
    .busy_i  (busy),
    .rdata_i (rdata),
    .raddr_o (raddr),
    .waddr_o (waddr),
    .launch_o(launch),
    .we_one_o(we_one),
    .we_all_o(we_all),
    .wdata_o (wdata),
    .do_o    (do_o),
    .do_oe_o (do_oe_o)
  );

  mw_word_array #(.WORDS(WORDS), .WIDTH(WIDTH), .AW(AW)) u_array (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_one_i(we_one),
    .we_all_i(we_all),
    .waddr_i (waddr),
    .wdata_i (wdata),
    .raddr_i (raddr),
    .rdata_o (rdata)
  );

  mw_prog_timer #(.CYCLES(PROG_CYCLES)) u_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .launch_i(launch),
    .busy_o  (busy)
  );

  // R2: output released once synchronized select is low
  a_r2_hiz_after_cs_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pins_s[2] |=> !do_oe_o);
  // R10: a new programming cycle never overlaps a running one
  a_r10_launch_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    launch |-> !busy);
endmodule

// File: tb/mw_eeprom_tb.sv
module mw_eeprom_tb;
  localparam int PROG = 60;
  localparam int H    = 4;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic cs = 1'b0, sk = 1'b0, di = 1'b0;
  logic do_w, do_oe;

  int checks = 0;
  int errors = 0;
  logic [15:0] model [128];
  bit wen_m = 1'b0;

  logic [15:0] exp_q [$];
  string       tag_q [$];
  logic [15:0] act_q [$];

  always #10 clk = ~clk;

  mw_eeprom #(.PROG_CYCLES(PROG)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .cs_i(cs), .sk_i(sk), .di_i(di),
    .do_o(do_w), .do_oe_o(do_oe)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h exp %h", tag, got, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (exp_q.size() > 0 && act_q.size() > 0) begin
      logic [15:0] e, a;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      a = act_q.pop_front();
      chk(t, {16'd0, a}, {16'd0, e});
    end
  end

  task automatic pulse(input logic b, output logic q);
    di = b;
    repeat (H) @(negedge clk);
    sk = 1'b1;
    repeat (H) @(negedge clk);
    sk = 1'b0;
    repeat (H) @(negedge clk);
    q = do_w;
  endtask

  task automatic send(input logic [31:0] v, input int n, output logic q);
    for (int i = n - 1; i >= 0; i--) pulse(v[i], q);
  endtask

  task automatic cs_on();
    cs = 1'b1;
    repeat (6) @(negedge clk);
  endtask

  task automatic cs_off();
    cs = 1'b0;
    di = 1'b0;
    repeat (8) @(negedge clk);
  endtask

  task automatic hdr(input logic [1:0] opc, input logic [7:0] adr, output logic q);
    logic x;
    pulse(1'b1, x);
    send({22'd0, opc, adr}, 10, q);
  endtask

  task automatic rd(input logic [7:0] adr, input int n, input string tag);
    logic q;
    logic [15:0] w;
    cs_on();
    hdr(2'b10, adr, q);
    chk({tag, " R3 dummy"}, {31'd0, q}, 32'd0);
    for (int k = 0; k < n; k++) begin
      exp_q.push_back(model[(adr[6:0] + k) % 128]);
      tag_q.push_back(tag);
      for (int b = 15; b >= 0; b--) begin
        pulse(1'b0, q);
        w[b] = q;
      end
      act_q.push_back(w);
    end
    cs_off();
  endtask

  task automatic wr(input logic [7:0] adr, input logic [15:0] d, input bit apply);
    logic q;
    cs_on();
    hdr(2'b01, adr, q);
    send({16'd0, d}, 16, q);
    cs_off();
    if (apply && wen_m) model[adr[6:0]] = d;
  endtask

  task automatic ctl(input logic [1:0] sub, input logic [15:0] d);
    logic q;
    cs_on();
    hdr(2'b00, {sub, 6'd0}, q);
    if (sub == 2'b01) send({16'd0, d}, 16, q);
    cs_off();
    if (sub == 2'b11) wen_m = 1'b1;
    if (sub == 2'b00) wen_m = 1'b0;
    if (wen_m && sub == 2'b10) for (int i = 0; i < 128; i++) model[i] = 16'hFFFF;
    if (wen_m && sub == 2'b01) for (int i = 0; i < 128; i++) model[i] = d;
  endtask

  task automatic erase(input logic [7:0] adr);
    logic q;
    cs_on();
    hdr(2'b11, adr, q);
    cs_off();
    if (wen_m) model[adr[6:0]] = 16'hFFFF;
  endtask

  // R9: busy seen on raise of select, then ready within the programming time
  task automatic busy_then_ready(input string tag);
    int n;
    cs_on();
    chk({tag, " R9 oe"}, {31'd0, do_oe}, 32'd1);
    chk({tag, " R9 busy"}, {31'd0, do_w}, 32'd0);
    n = 0;
    while (do_w !== 1'b1 && n < 4 * PROG) begin
      @(negedge clk);
      n++;
    end
    chk({tag, " R9 ready"}, {31'd0, do_w}, 32'd1);
    cs_off();
  endtask

  task automatic no_status(input string tag);
    cs_on();
    chk(tag, {31'd0, do_oe}, 32'd0);
    cs_off();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired got hang exp finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic q;
    for (int i = 0; i < 128; i++) model[i] = 16'hFFFF;
    repeat (5) @(negedge clk);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk);

    chk("R1 oe after reset", {31'd0, do_oe}, 32'd1 - 32'd1);
    rd(8'd3, 1, "R1 erased word");

    // R6: locked after reset
    wr(8'd5, 16'h1234, 1'b1);
    no_status("R6 no programming while locked");
    rd(8'd5, 1, "R6 locked write");

    ctl(2'b11, 16'h0);
    wr(8'd5, 16'hA5C3, 1'b1);
    busy_then_ready("first write");
    rd(8'd5, 1, "R5 write");
    wr(8'd5, 16'h0F0F, 1'b1);
    busy_then_ready("overwrite");
    rd(8'd5, 1, "R5 overwrite without erase");

    // R4: wrap 127 -> 0
    wr(8'd127, 16'h1357, 1'b1);
    busy_then_ready("w127");
    wr(8'd0, 16'h2468, 1'b1);
    busy_then_ready("w0");
    wr(8'd126, 16'h9ABC, 1'b1);
    busy_then_ready("w126");
    rd(8'd126, 3, "R4 sequential wrap");

    // R12: top address bit ignored
    wr(8'h8A, 16'h7E57, 1'b1);
    busy_then_ready("w8a");
    rd(8'h0A, 1, "R12 write with top bit");
    rd(8'h85, 1, "R12 read with top bit");

    // R13: leading zeros
    cs_on();
    send(32'd0, 3, q);
    hdr(2'b10, 8'd10, q);
    chk("R13 dummy", {31'd0, q}, 32'd0);
    begin
      logic [15:0] w;
      for (int b = 15; b >= 0; b--) begin
        pulse(1'b0, q);
        w[b] = q;
      end
      chk("R13 leading zeros", {16'd0, w}, {16'd0, model[10]});
    end
    cs_off();

    // R7: erase
    erase(8'd5);
    busy_then_ready("erase");
    rd(8'd5, 1, "R7 erase");

    // R10: instruction during busy
    wr(8'd20, 16'h1111, 1'b1);
    wr(8'd21, 16'h2222, 1'b0);
    repeat (4 * PROG) @(negedge clk);
    no_status("R10 no second programming");
    rd(8'd20, 2, "R10 busy ignore");

    // R11: cut short
    cs_on();
    hdr(2'b01, 8'd30, q);
    send(32'hAB, 8, q);
    cs_off();
    no_status("R11 no programming after abort");
    rd(8'd30, 1, "R11 aborted write");

    // R2: select low releases output mid-read
    cs_on();
    hdr(2'b10, 8'd0, q);
    pulse(1'b0, q);
    chk("R2 oe during read", {31'd0, do_oe}, 32'd1);
    cs_off();
    chk("R2 oe after select low", {31'd0, do_oe}, 32'd0);

    // R8: write-all, erase-all
    ctl(2'b01, 16'hBEEF);
    busy_then_ready("wral");
    rd(8'd126, 4, "R8 write-all");
    ctl(2'b10, 16'h0);
    busy_then_ready("eral");
    rd(8'd63, 2, "R8 erase-all");

    // R6: write-disable locks again
    wr(8'd40, 16'h4040, 1'b1);
    busy_then_ready("w40");
    ctl(2'b00, 16'h0);
    erase(8'd40);
    no_status("R6 no programming after disable");
    wr(8'd41, 16'h5555, 1'b1);
    rd(8'd40, 2, "R6 disabled");

    repeat (4) @(negedge clk);
    if (exp_q.size() != 0 || act_q.size() != 0) begin
      errors++;
      checks++;
      $display("FAIL scoreboard got %0d left exp 0", exp_q.size() + act_q.size());
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule